// File: doc/BRIEF.md
# Pipelined Longest Match Selector

This block sits behind a prefix-matching CAM. For every lookup the CAM reports, for each stored entry, whether the entry hit and how many leading address bits it matched. The selector reduces that vector to one winner, the entry with the longest match, and returns the winner's index as the next-hop pointer. The index goes on to a next-hop table, which is outside this block.

The reduction is a balanced binary tree of two-input compare nodes. Each node compares the match lengths of its two candidates. It derives a select from the compare and steers both the winning length and the winning index upward. A register follows every tree level, so a new lookup can enter on every clock and results leave in the order they entered.

Both ends use valid/ready. A lookup is accepted on a clock edge where `in_vld` and `in_rdy` are both high. A result is taken on an edge where `out_vld` and `out_rdy` are both high. While a result is offered but not taken, the whole pipeline freezes and `in_rdy` is low.

Top module: `lms_select_tree`

## Requirements
- R1: After reset and before any lookup is accepted, `out_vld` is low and `in_rdy` is high.
- R2: The result is the hitting entry whose match length is largest. Entry i has its hit flag at `in_hit[i]` and its length at `in_len[i*LEN_W +: LEN_W]`. `out_found` is 1, and `out_idx` and `out_len` are that entry's index and length.
- R3: When several hitting entries share the largest length, the lowest index among them is reported.
- R4: The length field of an entry whose hit flag is 0 has no effect on the result, whatever its value. A hitting entry of length 0 still beats every non-hitting entry.
- R5: When no entry hits, `out_found` is 0, `out_idx` is 0 and `out_len` is 0.
- R6: With `out_rdy` held high, a lookup accepted at clock edge A is taken as a result at edge A+log2(ENTRIES). Lookups may be accepted on consecutive edges, and at most log2(ENTRIES) lookups are in flight at once.
- R7: While `out_vld` is high and `out_rdy` is low, `in_rdy` is low, and `out_vld`, `out_found`, `out_idx` and `out_len` keep their values on the next cycle.
- R8: Whenever `out_vld` is low, `in_rdy` is high.
- R9: Results leave in the order the lookups were accepted, with none lost or duplicated under any pattern of `in_vld` and `out_rdy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A lookup vector is offered |
| in_rdy | output | 1 | The block accepts the offered lookup this cycle |
| in_hit | input | ENTRIES | Per-entry hit flag |
| in_len | input | ENTRIES*LEN_W | Per-entry match length, entry i at bits i*LEN_W upward |
| out_vld | output | 1 | A result is offered |
| out_rdy | input | 1 | The consumer takes the offered result this cycle |
| out_found | output | 1 | At least one entry hit |
| out_idx | output | log2(ENTRIES) | Index of the winning entry, 0 when none hit |
| out_len | output | LEN_W | Match length of the winner, 0 when none hit |

## Verification
The bench builds the block with 8 entries and 6-bit lengths. That gives a three-level tree with a three-cycle latency. With so few entries, a winner can be placed in every position, and random vectors drawn from a narrow length range produce ties in most lookups. It also makes the all-ones length of 63 a cheap value to plant in non-hitting entries, so a node that reads a length without its hit flag shows up at once. Random back-pressure holds results on the output for varying stretches while lookups keep arriving, so freeze, order and the limit on lookups in flight are all exercised at a small depth.

// File: rtl/lms_pkg.sv
`timescale 1ns/1ps
package lms_pkg;

  // Magnitude relation of the upper candidate's length against the lower one's.
  typedef struct packed {
    logic gt;
    logic lt;
  } len_cmp_t;

  // Select the upper (higher-index) candidate only if it hits and the lower
  // one either misses or is strictly shorter; equal lengths keep the lower.
  function automatic logic take_upper(input logic     lo_hit,
                                      input logic     hi_hit,
                                      input len_cmp_t rel);
    return hi_hit && (!lo_hit || (rel.gt && !rel.lt));
  endfunction

endpackage

// File: rtl/lms_cmp_node.sv
`timescale 1ns/1ps
module lms_cmp_node #(
  parameter int LEN_W = 6,
  parameter int IDX_W = 4
) (
  input  logic [LEN_W+IDX_W:0] lo_cand,
  input  logic [LEN_W+IDX_W:0] hi_cand,
  output logic [LEN_W+IDX_W:0] win_cand
);
  import lms_pkg::*;

  // candidate layout: {hit, length, index}
  logic             lo_hit, hi_hit;
  logic [LEN_W-1:0] lo_len, hi_len;
  logic [IDX_W-1:0] lo_idx, hi_idx;
  len_cmp_t         rel;
  logic             pick_hi;

  assign {lo_hit, lo_len, lo_idx} = lo_cand;
  assign {hi_hit, hi_len, hi_idx} = hi_cand;

  always_comb begin
    rel.gt  = hi_len > lo_len;
    rel.lt  = hi_len < lo_len;
    pick_hi = take_upper(lo_hit, hi_hit, rel);
    if (pick_hi)     win_cand = {1'b1, hi_len, hi_idx};
    else if (lo_hit) win_cand = {1'b1, lo_len, lo_idx};
    else             win_cand = '0;   // nothing hit: clean zero candidate
  end

endmodule

// File: rtl/lms_pipe_reg.sv
`timescale 1ns/1ps
module lms_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/lms_level.sv
`timescale 1ns/1ps
module lms_level #(
  parameter int LEN_W = 6,
  parameter int IDX_W = 4,
  parameter int N_IN  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                adv,
  input  logic                                in_vld,
  input  logic [N_IN*(LEN_W+IDX_W+1)-1:0]     in_cand,
  output logic                                out_vld,
  output logic [(N_IN/2)*(LEN_W+IDX_W+1)-1:0] out_cand
);
  localparam int CW    = LEN_W + IDX_W + 1;
  localparam int N_OUT = N_IN / 2;

  logic [N_OUT*CW-1:0] win_comb;
  logic [N_OUT*CW:0]   reg_q;

  for (genvar j = 0; j < N_OUT; j++) begin : g_node
    lms_cmp_node #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_node (
      .lo_cand (in_cand[(2*j)*CW +: CW]),
      .hi_cand (in_cand[(2*j+1)*CW +: CW]),
      .win_cand(win_comb[j*CW +: CW])
    );
  end

  lms_pipe_reg #(.W(N_OUT*CW+1)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (adv),
    .d    ({in_vld, win_comb}),
    .q    (reg_q)
  );

  assign out_vld  = reg_q[N_OUT*CW];
  assign out_cand = reg_q[N_OUT*CW-1:0];

endmodule

// File: rtl/lms_select_tree.sv
`timescale 1ns/1ps
module lms_select_tree #(
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  output logic                     in_rdy,
  input  logic [ENTRIES-1:0]       in_hit,
  input  logic [ENTRIES*LEN_W-1:0] in_len,
  output logic                     out_vld,
  input  logic                     out_rdy,
  output logic                     out_found,
  output logic [IDX_W-1:0]         out_idx,
  output logic [LEN_W-1:0]         out_len
);
  localparam int STAGES = IDX_W;
  localparam int CW     = LEN_W + IDX_W + 1;

  logic                  adv;
  logic [ENTRIES*CW-1:0] leaf;

  // Whole-pipe advance: move unless a finished result is waiting.
  assign adv    = !out_vld || out_rdy;
  assign in_rdy = adv;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_leaf
    assign leaf[i*CW +: CW] = {in_hit[i], in_len[i*LEN_W +: LEN_W], IDX_W'(i)};
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_lvl
    localparam int NI = ENTRIES >> k;
    logic [NI*CW-1:0]     cand_d;
    logic                 vld_d;
    logic [(NI/2)*CW-1:0] cand_q;
    logic                 vld_q;

    if (k == 0) begin : g_first
      assign cand_d = leaf;
      assign vld_d  = in_vld;
    end else begin : g_next
      assign cand_d = g_lvl[k-1].cand_q;
      assign vld_d  = g_lvl[k-1].vld_q;
    end

    lms_level #(.LEN_W(LEN_W), .IDX_W(IDX_W), .N_IN(NI)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .in_vld  (vld_d),
      .in_cand (cand_d),
      .out_vld (vld_q),
      .out_cand(cand_q)
    );
  end

  assign out_vld                      = g_lvl[STAGES-1].vld_q;
  assign {out_found, out_len, out_idx} = g_lvl[STAGES-1].cand_q;

endmodule

// File: rtl/lms_select_tree_chk.sv
`timescale 1ns/1ps
module lms_select_tree_chk #(
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             in_rdy,
  input logic             out_vld,
  input logic             out_rdy,
  input logic             out_found,
  input logic [IDX_W-1:0] out_idx,
  input logic [LEN_W-1:0] out_len
);
  localparam int STAGES = IDX_W;

  int inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else inflight <= inflight + ((in_vld && in_rdy) ? 1 : 0)
                              - ((out_vld && out_rdy) ? 1 : 0);
  end

  assert_nohit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_found) |-> (out_idx == '0 && out_len == '0));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_idx) && $stable(out_len)
                               && $stable(out_found)));

  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> in_rdy);

  assert_out_needs_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (inflight != 0));

  assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= STAGES);

endmodule

bind lms_select_tree lms_select_tree_chk #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_found(out_found),
  .out_idx(out_idx), .out_len(out_len)
);

// File: tb/lms_select_tree_tb_top.sv
`timescale 1ns/1ps
module lms_select_tree_tb_top;
  localparam int ENTRIES = 8;
  localparam int LEN_W   = 6;
  localparam int IDX_W   = 3;
  localparam int STAGES  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                     in_vld = 1'b0;
  logic                     in_rdy;
  logic [ENTRIES-1:0]       in_hit = '0;
  logic [ENTRIES*LEN_W-1:0] in_len = '0;
  logic                     out_vld;
  logic                     out_rdy = 1'b1;
  logic                     out_found;
  logic [IDX_W-1:0]         out_idx;
  logic [LEN_W-1:0]         out_len;

  lms_select_tree #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .in_hit(in_hit), .in_len(in_len), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_found(out_found), .out_idx(out_idx), .out_len(out_len)
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc   = 0;
  bit    bp_mode = 1'b0;
  bit    finished = 1'b0;
  int    q_idx[$];
  int    q_len[$];
  int    q_fnd[$];
  int    q_cyc[$];
  int    q_lat[$];
  string q_tag[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) out_rdy = bp_mode ? (($urandom % 4) != 0) : 1'b1;

  // Software argmax: longest hitting length, lowest index on ties.
  task automatic ref_best(input logic [ENTRIES-1:0] h, input logic [ENTRIES*LEN_W-1:0] l,
                          output int f, output int idx, output int len);
    f = 0; idx = 0; len = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (h[i] && (f == 0 || int'(l[i*LEN_W +: LEN_W]) > len)) begin
        f = 1; idx = i; len = int'(l[i*LEN_W +: LEN_W]);
      end
    end
  endtask

  // Result monitor, sampling well after the falling edge.
  logic             hold_pend = 1'b0;
  logic [IDX_W-1:0] h_idx;
  logic [LEN_W-1:0] h_len;
  logic             h_fnd;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hold_pend) begin
        check("R7", "out_vld held", int'(out_vld), 1);
        check("R7", "out_idx held", int'(out_idx), int'(h_idx));
        check("R7", "out_len held", int'(out_len), int'(h_len));
        check("R7", "out_found held", int'(out_found), int'(h_fnd));
      end
      hold_pend = 1'b0;
      if (!out_vld) check("R8", "in_rdy while idle", int'(in_rdy), 1);
      if (out_vld && !out_rdy) begin
        check("R7", "in_rdy during stall", int'(in_rdy), 0);
        hold_pend = 1'b1;
        h_idx = out_idx; h_len = out_len; h_fnd = out_found;
      end
      if (out_vld && out_rdy) begin
        if (q_idx.size() == 0) check("R9", "result with no lookup", 1, 0);
        else begin
          int ei, el, ef, ec, lat;
          string tg;
          ei = q_idx.pop_front(); el = q_len.pop_front(); ef = q_fnd.pop_front();
          ec = q_cyc.pop_front(); lat = q_lat.pop_front(); tg = q_tag.pop_front();
          check(tg, "out_found", int'(out_found), ef);
          check(tg, "out_idx", int'(out_idx), ei);
          check(tg, "out_len", int'(out_len), el);
          if (lat != 0) check("R6", "latency", cyc - ec, STAGES);
        end
      end
    end
  end

  task automatic send(input logic [ENTRIES-1:0] h, input logic [ENTRIES*LEN_W-1:0] l,
                      input int lat, input string tag);
    int ef, ei, el;
    @(negedge clk);
    in_vld = 1'b1; in_hit = h; in_len = l;
    #1;
    while (!in_rdy) begin
      @(negedge clk);
      #1;
    end
    ref_best(h, l, ef, ei, el);
    q_idx.push_back(ei); q_len.push_back(el); q_fnd.push_back(ef);
    q_cyc.push_back(cyc); q_lat.push_back(lat); q_tag.push_back(tag);
  endtask

  task automatic drain;
    @(negedge clk);
    in_vld = 1'b0;
    in_hit = ENTRIES'($urandom);
    in_len = '1;
    while (q_idx.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [ENTRIES*LEN_W-1:0] rand_lens(input int span);
    logic [ENTRIES*LEN_W-1:0] v;
    for (int i = 0; i < ENTRIES; i++) v[i*LEN_W +: LEN_W] = LEN_W'($urandom % span);
    return v;
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    #2;
    check("R1", "out_vld in reset", int'(out_vld), 0);
    check("R1", "in_rdy in reset", int'(in_rdy), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1", "out_vld after reset", int'(out_vld), 0);
    check("R1", "in_rdy after reset", int'(in_rdy), 1);
  endtask

  // A single hitting lane in each position; misses carry the largest length.
  task automatic t_single;
    logic [ENTRIES*LEN_W-1:0] l;
    for (int p = 0; p < ENTRIES; p++) begin
      l = '1;
      l[p*LEN_W +: LEN_W] = LEN_W'(5 + p);
      send(ENTRIES'(1) << p, l, 1, "R2/R4");
    end
    l = '0;
    for (int i = 0; i < ENTRIES; i++) l[i*LEN_W +: LEN_W] = LEN_W'(10 + ((i * 3) % ENTRIES));
    send('1, l, 1, "R2");
    drain();
  endtask

  task automatic t_ties;
    logic [ENTRIES*LEN_W-1:0] l;
    send('1, {ENTRIES{6'd20}}, 1, "R3");               // all equal: index 0
    l = '0;
    l[3*LEN_W +: LEN_W] = 6'd40; l[5*LEN_W +: LEN_W] = 6'd40; l[6*LEN_W +: LEN_W] = 6'd10;
    send(8'b0110_1000, l, 1, "R3");                      // lanes 3 and 5 tie
    l = '0;
    l[6*LEN_W +: LEN_W] = 6'd33; l[7*LEN_W +: LEN_W] = 6'd33;
    send(8'b1100_0000, l, 1, "R3");                      // lanes 6 and 7 tie
    l = '1;
    send(8'b0000_0110, l, 1, "R3");                      // lanes 1 and 2 at 63
    drain();
  endtask

  task automatic t_nohit;
    logic [ENTRIES*LEN_W-1:0] l;
    send('0, '1, 1, "R5");
    send('0, rand_lens(64), 1, "R5");
    l = '1;
    l[7*LEN_W +: LEN_W] = '0;
    send(8'b1000_0000, l, 1, "R4");                      // zero-length hit beats misses
    l = '1;
    l[0 +: LEN_W] = 6'd1;
    send(8'b0000_0001, l, 1, "R4");
    drain();
  endtask

  task automatic t_b2b;
    for (int n = 0; n < 150; n++)
      send(ENTRIES'($urandom), rand_lens((n % 2 == 0) ? 4 : 64), 1, "R2/R3/R6/R9");
    drain();
  endtask

  task automatic t_backpressure;
    bp_mode = 1'b1;
    for (int n = 0; n < 150; n++) begin
      send(ENTRIES'($urandom), rand_lens((n % 3 == 0) ? 64 : 6), 0, "R7/R9");
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        in_vld = 1'b0;
      end
    end
    drain();
    bp_mode = 1'b0;
    drain();
  endtask

  initial begin
    t_reset();
    t_single();
    t_ties();
    t_nohit();
    t_b2b();
    t_backpressure();
    check("R9", "results outstanding", q_idx.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule